// File: doc/BRIEF.md
# Up-Counting Interval Timer with Two Compare Channels

This block is a single up-counting timer attached to a byte-addressed register bus. Once software sets the run bit in the upper mode byte, the counter starts from zero and advances by one on every clock in which the `tick_i` qualifier is high. Compare register A sets the period. When the next count would equal compare A, the counter returns to zero and a one-cycle period pulse is produced. Compare register B does not change counting. It only marks, with its own one-cycle pulse, the tick on which the count reaches its value.

The mode register is split into two bytes, and each byte has its own reserved-bit rules. Two compare-mode bytes are held for software but have no effect on counting. Every illegal access is dropped without changing any state, and it sets an error flag that stays high until reset. Reads are combinational, so `bus_rdata_o` is valid in the same cycle as the access.

Top module: `tmr_updual`

## Requirements
- R1: After reset, every register reads 0, the counter reads 0, and `period_o`, `match_a_o`, `match_b_o` and `err_o` are low.
- R2: The lower mode byte is at offset 0x84 and the upper mode byte is at 0x85, and both accept byte access. A halfword access is legal only at 0x84: write data bits 7:0 go to 0x84, bits 15:8 go to 0x85, and a read returns {0x85, 0x84}. A halfword access at 0x85 is an error.
- R3: A lower-mode write with any of bits 5, 3 or 2 set is illegal. An upper-mode write with any of bits 2:0 set, or with bit 7 and bit 6 both set, is illegal. An illegal mode write changes no mode bit and does not restart the counter. Bit 6 is stored and read back.
- R4: While upper-mode bit 7 (run) is 1, the counter at 0xa4 rises by one on each cycle with `tick_i` high and holds otherwise. While run is 0, the counter reads 0.
- R5: When compare A is non-zero and the next count would equal it, the counter reads 0 in the following cycle, and `period_o` and `match_a_o` are high for exactly that cycle. This gives one pulse every compare-A ticks.
- R6: When compare A is 0, no period or match-A pulse is produced, and the counter wraps modulo 2^16.
- R7: `match_b_o` is high for one cycle after a tick whose reached count (count plus one, modulo 2^16) equals compare B. This includes the tick on which a period restart happens.
- R8: Every accepted write that reaches the upper mode byte, whether a byte at 0x85 or a halfword at 0x84, restarts the count from zero and suppresses that cycle's tick.
- R9: Compare A (0xc4) and compare B (0xd4) accept byte or halfword access. A byte write stores the byte zero-extended, and a byte read returns the low byte in bits 7:0.
- R10: Compare-mode bytes at 0xb4 and 0xb5 are byte-only. They are stored and read back with no effect on counting. A halfword access to either one is an error and is ignored.
- R11: The counter is read-only, so a write to 0xa4 is an error and changes nothing. Any unmapped offset is an error and reads 0. A byte read returns 0 in bits 15:8.
- R12: `err_o` is set by any illegal access and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count qualifier, one count per high cycle |
| bus_en_i | input | 1 | Access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 for a write, 0 for a read |
| bus_half_i | input | 1 | 1 for a halfword access, 0 for a byte access |
| bus_addr_i | input | AW | Byte offset |
| bus_wdata_i | input | 16 | Write data, byte writes use bits 7:0 |
| bus_rdata_o | output | 16 | Read data, combinational, 0 when not reading |
| period_o | output | 1 | Period restart pulse |
| match_a_o | output | 1 | Compare-A match pulse |
| match_b_o | output | 1 | Compare-B match pulse |
| err_o | output | 1 | Sticky illegal-access flag |

## Verification
The hardest situation to reach is the free-running wrap with compare A at zero. It needs 65,536 consecutive ticks with no intervening restart, after which compare B at zero must fire exactly once and no period pulse may appear. The stimulus clears both compare registers, restarts the count through an upper-mode write and holds `tick_i` high across the full span. A second difficult case is a match-B pulse that falls on the same tick as a period restart. It is reached by setting compare B equal to compare A. Rejected mode writes are issued while the counter runs, so any unwanted restart shows up in the very next counter comparison.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam logic [7:0] OFS_MODE_LO  = 8'h84;
  localparam logic [7:0] OFS_MODE_HI  = 8'h85;
  localparam logic [7:0] OFS_COUNT    = 8'ha4;
  localparam logic [7:0] OFS_CMODE_A  = 8'hb4;
  localparam logic [7:0] OFS_CMODE_B  = 8'hb5;
  localparam logic [7:0] OFS_CMP_A    = 8'hc4;
  localparam logic [7:0] OFS_CMP_B    = 8'hd4;

  localparam logic [7:0] MODE_LO_RSVD = 8'h2C;
  localparam logic [7:0] MODE_HI_RSVD = 8'h07;
  localparam int unsigned RUN_BIT     = 7;
  localparam int unsigned LOAD_BIT    = 6;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MLO, SEL_MHI, SEL_CNT, SEL_CMA, SEL_CMB, SEL_CPA, SEL_CPB
  } reg_sel_e;

  function automatic logic mode_lo_legal(input logic [7:0] v);
    return (v & MODE_LO_RSVD) == 8'h00;
  endfunction

  function automatic logic mode_hi_legal(input logic [7:0] v);
    return ((v & MODE_HI_RSVD) == 8'h00) && !(v[RUN_BIT] && v[LOAD_BIT]);
  endfunction

  function automatic reg_sel_e decode_ofs(input logic [7:0] a);
    case (a)
      OFS_MODE_LO: return SEL_MLO;
      OFS_MODE_HI: return SEL_MHI;
      OFS_COUNT:   return SEL_CNT;
      OFS_CMODE_A: return SEL_CMA;
      OFS_CMODE_B: return SEL_CMB;
      OFS_CMP_A:   return SEL_CPA;
      OFS_CMP_B:   return SEL_CPB;
      default:     return SEL_NONE;
    endcase
  endfunction

  function automatic logic half_allowed(input reg_sel_e s);
    return s inside {SEL_MLO, SEL_CNT, SEL_CPA, SEL_CPB};
  endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          en,
  input  logic          wr,
  input  logic          half,
  input  logic [AW-1:0] addr,
  output reg_sel_e      sel,
  output logic          acc_bad
);

  logic hi_ok;

  generate
    if (AW > 8) begin : g_wide
      assign hi_ok = (addr[AW-1:8] == '0);
    end else begin : g_narrow
      assign hi_ok = 1'b1;
    end
  endgenerate

  assign sel = hi_ok ? decode_ofs(addr[7:0]) : SEL_NONE;

  assign acc_bad = en & ((sel == SEL_NONE)
                       | (half & !half_allowed(sel))
                       | (wr & (sel == SEL_CNT)));

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          wr,
  input  logic          half,
  input  reg_sel_e      sel,
  input  logic          acc_bad,
  input  logic [15:0]   wdata,
  output logic [7:0]    mode_lo,
  output logic [7:0]    mode_hi,
  output logic [7:0]    cmode_a,
  output logic [7:0]    cmode_b,
  output logic [CW-1:0] cmp_a,
  output logic [CW-1:0] cmp_b,
  output logic          err,
  output logic          hi_write
);

  logic          content_ok;
  logic          wr_ok;
  logic          bad_now;
  logic [CW-1:0] cmp_val;

  always_comb begin
    case (sel)
      SEL_MLO: content_ok = half ? (mode_lo_legal(wdata[7:0]) && mode_hi_legal(wdata[15:8]))
                                 : mode_lo_legal(wdata[7:0]);
      SEL_MHI: content_ok = mode_hi_legal(wdata[7:0]);
      default: content_ok = 1'b1;
    endcase
  end

  assign wr_ok    = en & wr & ~acc_bad & content_ok;
  assign bad_now  = acc_bad | (en & wr & ~content_ok);
  assign hi_write = wr_ok & ((sel == SEL_MHI) | ((sel == SEL_MLO) & half));
  assign cmp_val  = half ? wdata[CW-1:0] : CW'(wdata[7:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_lo <= '0;
      mode_hi <= '0;
      cmode_a <= '0;
      cmode_b <= '0;
      cmp_a   <= '0;
      cmp_b   <= '0;
      err     <= 1'b0;
    end else begin
      if (bad_now) err <= 1'b1;
      if (wr_ok) begin
        case (sel)
          SEL_MLO: begin
            mode_lo <= wdata[7:0];
            if (half) mode_hi <= wdata[15:8];
          end
          SEL_MHI: mode_hi <= wdata[7:0];
          SEL_CMA: cmode_a <= wdata[7:0];
          SEL_CMB: cmode_b <= wdata[7:0];
          SEL_CPA: cmp_a   <= cmp_val;
          SEL_CPB: cmp_b   <= cmp_val;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          run,
  input  logic          restart,
  input  logic [CW-1:0] cmp_a,
  input  logic [CW-1:0] cmp_b,
  output logic [CW-1:0] cnt,
  output logic          hit_a,
  output logic          hit_b,
  output logic          period_q,
  output logic          match_b_q
);

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] c);
    return c + CW'(1);
  endfunction

  logic [CW-1:0] nxt;
  logic          step;

  assign nxt   = bump(cnt);
  assign step  = run & tick & ~restart;
  assign hit_a = step & (cmp_a != '0) & (nxt == cmp_a);
  assign hit_b = step & (nxt == cmp_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      period_q  <= 1'b0;
      match_b_q <= 1'b0;
    end else begin
      period_q  <= hit_a;
      match_b_q <= hit_b;
      if (restart || !run) cnt <= '0;
      else if (step)       cnt <= hit_a ? '0 : nxt;
    end
  end

endmodule

// File: rtl/tmr_updual.sv
module tmr_updual
  import tmr_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          bus_en_i,
  input  logic          bus_wr_i,
  input  logic          bus_half_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [15:0]   bus_wdata_i,
  output logic [15:0]   bus_rdata_o,
  output logic          period_o,
  output logic          match_a_o,
  output logic          match_b_o,
  output logic          err_o
);

  reg_sel_e      sel;
  logic          acc_bad;
  logic [7:0]    mode_lo, mode_hi, cmode_a, cmode_b;
  logic [CW-1:0] cmp_a, cmp_b, cnt;
  logic          hi_write;
  logic          run_w;
  logic          hit_a, hit_b;
  logic          period_q, match_b_q;
  logic [15:0]   rd_word;

  tmr_decode #(.AW(AW)) u_dec (
    .en(bus_en_i), .wr(bus_wr_i), .half(bus_half_i), .addr(bus_addr_i),
    .sel(sel), .acc_bad(acc_bad)
  );

  tmr_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst(rst), .en(bus_en_i), .wr(bus_wr_i), .half(bus_half_i),
    .sel(sel), .acc_bad(acc_bad), .wdata(bus_wdata_i),
    .mode_lo(mode_lo), .mode_hi(mode_hi), .cmode_a(cmode_a), .cmode_b(cmode_b),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .err(err_o), .hi_write(hi_write)
  );

  assign run_w = mode_hi[RUN_BIT];

  tmr_core #(.CW(CW)) u_core (
    .clk(clk), .rst(rst), .tick(tick_i), .run(run_w), .restart(hi_write),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .cnt(cnt), .hit_a(hit_a), .hit_b(hit_b),
    .period_q(period_q), .match_b_q(match_b_q)
  );

  always_comb begin
    case (sel)
      SEL_MLO: rd_word = {mode_hi, mode_lo};
      SEL_MHI: rd_word = {8'h00, mode_hi};
      SEL_CNT: rd_word = 16'(cnt);
      SEL_CMA: rd_word = {8'h00, cmode_a};
      SEL_CMB: rd_word = {8'h00, cmode_b};
      SEL_CPA: rd_word = 16'(cmp_a);
      SEL_CPB: rd_word = 16'(cmp_b);
      default: rd_word = '0;
    endcase
  end

  assign bus_rdata_o = (bus_en_i & ~bus_wr_i & ~acc_bad)
                     ? (bus_half_i ? rd_word : {8'h00, rd_word[7:0]})
                     : '0;

  assign period_o  = period_q;
  assign match_a_o = period_q;
  assign match_b_o = match_b_q;

endmodule

// File: rtl/tmr_updual_chk.sv
module tmr_updual_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic          hi_write,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cmp_a,
  input logic          period,
  input logic          err
);

  logic [CW-1:0] cnt_inc;
  assign cnt_inc = cnt + CW'(1);

  p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));

  p_restart_zero_r5: assert property (@(posedge clk) disable iff (rst)
    period |-> (cnt == '0));

  p_period_reach_r5: assert property (@(posedge clk) disable iff (rst)
    period |-> ($past(cnt_inc) == $past(cmp_a)));

  p_cmpa_zero_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(cmp_a) == '0) |-> !period);

  p_write_restart_r8: assert property (@(posedge clk) disable iff (rst)
    hi_write |=> (cnt == '0));

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

endmodule

bind tmr_updual tmr_updual_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .run(run_w), .hi_write(hi_write), .cnt(cnt),
  .cmp_a(cmp_a), .period(period_o), .err(err_o)
);

// File: tb/tmr_updual_bench.sv
module tmr_updual_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b1;
  logic        bus_en = 1'b0, bus_wr = 1'b0, bus_half = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        period_o, match_a_o, match_b_o, err_o;

  int n_chk = 0, n_bad = 0, n_per = 0, n_mb = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_updual u_tmr_updual (
    .clk(clk), .rst(rst), .tick_i(tick), .bus_en_i(bus_en), .bus_wr_i(bus_wr),
    .bus_half_i(bus_half), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .period_o(period_o), .match_a_o(match_a_o),
    .match_b_o(match_b_o), .err_o(err_o)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model
  int m_lo, m_hi, m_cma, m_cmb, m_pa, m_pb, m_cnt;
  bit m_err, m_pe, m_pmb;

  function automatic bit m_bad(int a, bit h, bit w);
    if (!(a inside {'h84, 'h85, 'ha4, 'hb4, 'hb5, 'hc4, 'hd4})) return 1;
    if (h && !(a inside {'h84, 'ha4, 'hc4, 'hd4})) return 1;
    if (w && a == 'ha4) return 1;
    return 0;
  endfunction

  function automatic bit lo_ok(int v); return (v & 'h2C) == 0; endfunction
  function automatic bit hi_ok(int v); return ((v & 7) == 0) && ((v & 'hC0) != 'hC0); endfunction

  function automatic int m_read(int a, bit h);
    int v;
    if (m_bad(a, h, 0)) return 0;
    case (a)
      'h84: v = m_hi * 256 + m_lo;
      'h85: v = m_hi;
      'ha4: v = m_cnt;
      'hb4: v = m_cma;
      'hb5: v = m_cmb;
      'hc4: v = m_pa;
      default: v = m_pb;
    endcase
    return h ? v : (v & 'hFF);
  endfunction

  always @(posedge clk) begin
    int a, d, nxt;
    bit h, bad, accept, hiw, step, ok, run;
    if (rst) begin
      m_lo = 0; m_hi = 0; m_cma = 0; m_cmb = 0; m_pa = 0; m_pb = 0; m_cnt = 0;
      m_err = 0; m_pe = 0; m_pmb = 0;
    end else begin
      a = int'(bus_addr); d = int'(bus_wdata); h = bus_half;
      bad = bus_en && m_bad(a, h, bus_wr);
      accept = 0;
      if (bus_en && bus_wr && !bad) begin
        ok = 1;
        if (a == 'h84) ok = lo_ok(d & 'hFF) && (!h || hi_ok((d >> 8) & 'hFF));
        if (a == 'h85) ok = hi_ok(d & 'hFF);
        if (ok) accept = 1; else bad = 1;
      end
      hiw = accept && (a == 'h85 || (a == 'h84 && h));
      run = (m_hi >> 7) & 1;
      nxt = (m_cnt + 1) & 'hFFFF;
      step = run && tick && !hiw;
      m_pe = step && m_pa != 0 && nxt == m_pa;
      m_pmb = step && nxt == m_pb;
      if (hiw || !run) m_cnt = 0;
      else if (step) m_cnt = m_pe ? 0 : nxt;
      if (accept) begin
        case (a)
          'h84: begin m_lo = d & 'hFF; if (h) m_hi = (d >> 8) & 'hFF; end
          'h85: m_hi = d & 'hFF;
          'hb4: m_cma = d & 'hFF;
          'hb5: m_cmb = d & 'hFF;
          'hc4: m_pa = h ? (d & 'hFFFF) : (d & 'hFF);
          'hd4: m_pb = h ? (d & 'hFFFF) : (d & 'hFF);
          default: ;
        endcase
      end
      if (bad) m_err = 1;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R5 period_o", int'(period_o), int'(m_pe));
      check("R5 match_a_o", int'(match_a_o), int'(m_pe));
      check("R7 match_b_o", int'(match_b_o), int'(m_pmb));
      check("R12 err_o", int'(err_o), int'(m_err));
      if (period_o) n_per++;
      if (match_b_o) n_mb++;
    end
  end

  task automatic bus_put(bit w, int a, bit h, int d);
    bus_en = 1; bus_wr = w; bus_half = h; bus_addr = a[7:0]; bus_wdata = d[15:0];
  endtask

  task automatic bwr(int a, bit h, int d);
    bus_put(1, a, h, d);
    @(negedge clk);
    bus_en = 0; bus_wr = 0;
  endtask

  task automatic brd(string tag, int a, bit h);
    bus_put(0, a, h, 0);
    #1;
    check(tag, int'(bus_rdata), m_read(a, h));
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 0;
    // R1 reset state
    brd("R1 mode half", 'h84, 1);
    brd("R1 counter", 'ha4, 1);
    brd("R1 cmode a", 'hb4, 0);
    brd("R1 cmode b", 'hb5, 0);
    brd("R1 cmp a", 'hc4, 1);
    brd("R1 cmp b", 'hd4, 1);
    check("R1 err", int'(err_o), 0);
    // R2 mode byte and halfword paths
    bwr('h84, 0, 'h51);
    brd("R2 mode lo byte", 'h84, 0);
    bwr('h85, 0, 'h08);
    brd("R2 mode half", 'h84, 1);
    bwr('h84, 1, 'h1013);
    brd("R2 mode half after half write", 'h84, 1);
    brd("R2 mode hi byte", 'h85, 0);
    // R9 compare registers
    bwr('hc4, 0, 'h1234);
    brd("R9 cmp a byte write", 'hc4, 1);
    bwr('hc4, 1, 5);
    bwr('hd4, 1, 3);
    brd("R9 cmp b byte read", 'hd4, 0);
    brd("R9 cmp a half read", 'hc4, 1);
    // R4 R5 R7 counting with steady tick
    bwr('h85, 0, 'h80);
    for (int i = 0; i < 12; i++) brd("R4 counter running", 'ha4, 1);
    // R4 irregular tick
    for (int i = 0; i < 30; i++) begin
      tick = (i % 3) != 0;
      brd("R4 counter gated tick", 'ha4, 0);
    end
    tick = 1;
    // R7 match_b on the restart tick
    bwr('hd4, 1, 5);
    idle(20);
    check("R7 match_b seen", int'(n_mb > 0), 1);
    // R8 restart by mode writes
    idle(2);
    bwr('h85, 0, 'h80);
    brd("R8 restart byte", 'ha4, 1);
    idle(2);
    bwr('h84, 1, 'h8000);
    brd("R8 restart half", 'ha4, 1);
    // R6 free run with wrap
    bwr('hc4, 1, 0);
    bwr('hd4, 1, 0);
    bwr('h85, 0, 'h80);
    n_per = 0; n_mb = 0;
    idle(65540);
    check("R6 no period pulses", n_per, 0);
    check("R6 wrap match_b count", n_mb, 1);
    brd("R6 counter after wrap", 'ha4, 1);
    bwr('hc4, 1, 7);
    // R10 compare-mode bytes
    bwr('hb4, 0, 'hA5);
    bwr('hb5, 0, 'h5A);
    brd("R10 cmode a", 'hb4, 0);
    brd("R10 cmode b", 'hb5, 0);
    brd("R10 counter unaffected", 'ha4, 1);
    bwr('hb4, 1, 'h1111);
    brd("R10 cmode a after bad half", 'hb4, 0);
    brd("R10 half read zero", 'hb5, 1);
    // R12 sticky
    bwr('hd4, 1, 2);
    check("R12 err stays set", int'(err_o), 1);
    // R3 illegal mode writes while running
    bwr('h84, 0, 'h24);
    brd("R3 mode lo unchanged", 'h84, 0);
    bwr('h85, 0, 'hC0);
    brd("R3 counter not restarted", 'ha4, 1);
    bwr('h85, 0, 'h81);
    bwr('h84, 1, 'h0100);
    brd("R3 mode unchanged half", 'h84, 1);
    bwr('h85, 0, 'h40);
    brd("R3 load bit stored", 'h85, 0);
    bwr('h85, 0, 'h80);
    idle(4);
    // R11 read-only counter and unmapped
    bwr('ha4, 1, 7);
    brd("R11 counter after write", 'ha4, 1);
    brd("R11 unmapped read", 'h00, 0);
    bwr('h10, 0, 'hFF);
    brd("R11 byte read upper zero", 'hc4, 0);
    // R2 halfword at upper mode byte
    bwr('h85, 1, 'h0080);
    brd("R2 half at 0x85 reads zero", 'h85, 1);
    brd("R2 mode after bad half", 'h84, 1);
    // R4 stop reads zero
    bwr('h85, 0, 'h00);
    idle(3);
    brd("R4 stopped reads zero", 'ha4, 1);
    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule